// File: doc/BRIEF.md
# Programmed-I/O Block Buffer for a Cipher Core

This block sits between a processor's register interface and a 128-bit block-cipher core. Software pushes plaintext or ciphertext one 32-bit word at a time into an input buffer. Once four words are present, the buffer offers the assembled block to the core over a valid/ready handshake.

In the other direction, the core hands a finished block to an output buffer. Software then drains it one word per read. Each buffer holds exactly one block.

Software polls a status word that reports empty and full for both buffers. The same word carries two sticky error flags: one for a write into a full input buffer and one for a read from an empty output buffer. Two independent control bits reverse the byte order of words on the way in and on the way out. A start pulse, given at the beginning of an operation, flushes both buffers and clears the error flags.

Top module: `cipher_pio_buffer`

## Requirements
- R1: After reset, and in the cycle after a start pulse, both buffers hold no words. Status bit 8 (input empty) and bit 16 (output empty) read 1. Bits 9, 10, 17 and 18 read 0. All other status bits are always 0.
- R2: Each accepted write adds one word to the input buffer. Status bit 8 is 1 only while the input buffer holds zero words. Status bit 9 is 1 only while it holds four words.
- R3: The input block is offered (`blk_out_valid_o`) only while all four words are present. The word written k-th (k = 0..3) appears at bits [32k+31:32k] of `blk_out_data_o`. A handshake on the offer empties the input buffer.
- R4: A write while status bit 9 is 1 is dropped, and it sets the input error flag at status bit 10. The offered block is left unchanged.
- R5: The output buffer accepts a core block (`blk_in_ready_o` high) only while it is empty. After a load it holds four words. Status bit 17 is 1 while it holds four words, and bit 16 is 1 while it holds none.
- R6: A read of a non-empty output buffer returns the next word on `rd_data_o` in the following cycle. Words come out in order, bits [31:0] of the loaded block first. Each read removes one word.
- R7: A read while status bit 16 is 1 returns zero in the following cycle, sets the output error flag at status bit 18, and consumes no word.
- R8: Both error flags stay set until a start pulse, which also discards any buffered words.
- R9: With `in_swap_i` high, a written word {b3,b2,b1,b0} is stored as {b0,b1,b2,b3}.
- R10: With `out_swap_i` high, a returned word has its bytes reversed in the same way. This is independent of `in_swap_i` and is applied at read time.
- R11: In a cycle with `start_i` high, writes, reads and both core handshakes are ignored. Both `blk_out_valid_o` and `blk_in_ready_o` are held low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse: flush buffers and clear error flags |
| in_swap_i | input | 1 | Reverse byte order of written words |
| out_swap_i | input | 1 | Reverse byte order of read words |
| wr_en_i | input | 1 | Word write strobe |
| wr_data_i | input | 32 | Word written by software |
| rd_en_i | input | 1 | Word read strobe |
| rd_data_o | output | 32 | Word returned one cycle after a read |
| status_o | output | 32 | Empty/full/error flags at bits 8,9,10,16,17,18 |
| blk_out_data_o | output | 128 | Block offered to the cipher core |
| blk_out_valid_o | output | 1 | Offered block is complete |
| blk_out_ready_i | input | 1 | Core takes the offered block |
| blk_in_data_i | input | 128 | Result block from the cipher core |
| blk_in_valid_i | input | 1 | Core presents a result block |
| blk_in_ready_o | output | 1 | Output buffer can take a block |

## Verification
A wrong word count in either buffer shows in the status word in the very next cycle. It appears as an empty or full flag at the wrong moment, or as an error flag raised on a legal access.

A wrong write or read index shows as a misplaced word. For the input buffer, the misplaced word appears in `blk_out_data_o` as soon as the fourth word lands. For the output buffer, it appears on `rd_data_o` one cycle after the affected read.

Swap mistakes surface on the first word that crosses the affected direction. A lost start flush shows one cycle after the pulse.

// File: rtl/cipher_pio_pkg.sv
package cipher_pio_pkg;
  // status word layout
  localparam int ST_IN_EMPTY  = 8;
  localparam int ST_IN_FULL   = 9;
  localparam int ST_IN_ERR    = 10;
  localparam int ST_OUT_EMPTY = 16;
  localparam int ST_OUT_FULL  = 17;
  localparam int ST_OUT_ERR   = 18;
  localparam int ST_W         = 32;
endpackage

// File: rtl/cpb_byte_rev.sv
module cpb_byte_rev #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  input  logic         en,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;
  logic [W-1:0] rev;
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign rev[8*b +: 8] = din[W-8-8*b +: 8];
  end
  assign dout = en ? rev : din;
endmodule

// File: rtl/cpb_in_buf.sv
module cpb_in_buf #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         swap,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W*N-1:0] blk_data,
  output logic         blk_valid,
  input  logic         blk_ready,
  output logic         empty,
  output logic         full,
  output logic         err
);
  localparam int CW = $clog2(N + 1);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [W-1:0]  mem [N];
  logic [CW-1:0] cnt;
  logic [W-1:0]  wr_word;
  logic          accept, take;

  cpb_byte_rev #(.W(W)) u_rev (.din(wr_data), .en(swap), .dout(wr_word));

  assign full      = (cnt == CW'(N));
  assign empty     = (cnt == '0);
  assign blk_valid = full && !clr;
  assign take      = blk_valid && blk_ready;
  assign accept    = wr_en && !full && !clr;

  always_ff @(posedge clk) begin
    if (accept) mem[cnt[PW-1:0]] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (take)   cnt <= '0;
    else if (accept) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)              err <= 1'b0;
    else if (wr_en && full)      err <= 1'b1;
  end

  for (genvar k = 0; k < N; k++) begin : g_pack
    assign blk_data[W*k +: W] = mem[k];
  end
endmodule

// File: rtl/cpb_out_buf.sv
module cpb_out_buf #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           swap,
  input  logic [W*N-1:0] blk_data,
  input  logic           blk_valid,
  output logic           blk_ready,
  input  logic           rd_en,
  output logic [W-1:0]   rd_data,
  output logic           empty,
  output logic           full,
  output logic           err
);
  localparam int CW = $clog2(N + 1);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [W-1:0]  mem [N];
  logic [CW-1:0] cnt;
  logic [CW-1:0] idx;
  logic [W-1:0]  head, head_sw;
  logic          load, pop;

  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(N));
  assign blk_ready = empty && !clr;
  assign load      = blk_ready && blk_valid;
  assign pop       = rd_en && !empty && !clr;
  assign idx       = CW'(N) - cnt;
  assign head      = mem[idx[PW-1:0]];

  cpb_byte_rev #(.W(W)) u_rev (.din(head), .en(swap), .dout(head_sw));

  for (genvar k = 0; k < N; k++) begin : g_load
    always_ff @(posedge clk) begin
      if (load) mem[k] <= blk_data[W*k +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (load)   cnt <= CW'(N);
    else if (pop)    cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                      rd_data <= '0;
    else if (pop)                 rd_data <= head_sw;
    else if (rd_en && !clr)       rd_data <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)               err <= 1'b0;
    else if (rd_en && empty)      err <= 1'b1;
  end
endmodule

// File: rtl/cipher_pio_buffer.sv
module cipher_pio_buffer
  import cipher_pio_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BLK_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              in_swap_i,
  input  logic              out_swap_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [ST_W-1:0]   status_o,
  output logic [BLK_W-1:0]  blk_out_data_o,
  output logic              blk_out_valid_o,
  input  logic              blk_out_ready_i,
  input  logic [BLK_W-1:0]  blk_in_data_i,
  input  logic              blk_in_valid_i,
  output logic              blk_in_ready_o
);
  logic in_empty, in_full, in_err;
  logic out_empty, out_full, out_err;

  cpb_in_buf #(.W(WORD_W), .N(WORDS)) u_in (
    .clk(clk), .rst(rst), .clr(start_i), .swap(in_swap_i),
    .wr_en(wr_en_i), .wr_data(wr_data_i),
    .blk_data(blk_out_data_o), .blk_valid(blk_out_valid_o), .blk_ready(blk_out_ready_i),
    .empty(in_empty), .full(in_full), .err(in_err)
  );

  cpb_out_buf #(.W(WORD_W), .N(WORDS)) u_out (
    .clk(clk), .rst(rst), .clr(start_i), .swap(out_swap_i),
    .blk_data(blk_in_data_i), .blk_valid(blk_in_valid_i), .blk_ready(blk_in_ready_o),
    .rd_en(rd_en_i), .rd_data(rd_data_o),
    .empty(out_empty), .full(out_full), .err(out_err)
  );

  always_comb begin
    status_o               = '0;
    status_o[ST_IN_EMPTY]  = in_empty;
    status_o[ST_IN_FULL]   = in_full;
    status_o[ST_IN_ERR]    = in_err;
    status_o[ST_OUT_EMPTY] = out_empty;
    status_o[ST_OUT_FULL]  = out_full;
    status_o[ST_OUT_ERR]   = out_err;
  end
endmodule

// File: rtl/cipher_pio_buffer_chk.sv
module cipher_pio_buffer_chk #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int BLK_W = WORD_W * WORDS
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              in_swap_i,
  input logic              out_swap_i,
  input logic              wr_en_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic              rd_en_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic [31:0]       status_o,
  input logic [BLK_W-1:0]  blk_out_data_o,
  input logic              blk_out_valid_o,
  input logic              blk_out_ready_i,
  input logic [BLK_W-1:0]  blk_in_data_i,
  input logic              blk_in_valid_i,
  input logic              blk_in_ready_o
);
  assert_start_clears_R1: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (status_o[8] && status_o[16] && !status_o[10] && !status_o[18]));

  assert_take_empties_R3: assert property (@(posedge clk) disable iff (rst)
    (blk_out_valid_o && blk_out_ready_i) |=> status_o[8]);

  assert_full_holds_block_R4: assert property (@(posedge clk) disable iff (rst)
    (blk_out_valid_o && !blk_out_ready_i && !start_i) |=> $stable(blk_out_data_o));

  assert_overrun_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && status_o[9] && !start_i) |=> status_o[10]);

  assert_load_fills_R5: assert property (@(posedge clk) disable iff (rst)
    (blk_in_valid_i && blk_in_ready_o) |=> status_o[17]);

  assert_underrun_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && status_o[16] && !start_i) |=> (rd_data_o == '0 && status_o[18]));

  assert_in_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (status_o[10] && !start_i) |=> status_o[10]);

  assert_out_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (status_o[18] && !start_i) |=> status_o[18]);

  assert_start_blocks_hs_R11: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (!blk_out_valid_o && !blk_in_ready_o));
endmodule

bind cipher_pio_buffer cipher_pio_buffer_chk #(.WORD_W(WORD_W), .WORDS(WORDS)) u_chk (.*);

// File: tb/cipher_pio_buffer_tb.sv
module cipher_pio_buffer_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst = 1'b1, start_i = 0, in_swap_i = 0, out_swap_i = 0;
  logic         wr_en_i = 0, rd_en_i = 0, blk_out_ready_i = 0, blk_in_valid_i = 0;
  logic [31:0]  wr_data_i = '0;
  logic [127:0] blk_in_data_i = '0;
  logic [31:0]  rd_data_o, status_o;
  logic [127:0] blk_out_data_o;
  logic         blk_out_valid_o, blk_in_ready_o;

  cipher_pio_buffer u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .in_swap_i(in_swap_i), .out_swap_i(out_swap_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .status_o(status_o), .blk_out_data_o(blk_out_data_o), .blk_out_valid_o(blk_out_valid_o),
    .blk_out_ready_i(blk_out_ready_i), .blk_in_data_i(blk_in_data_i),
    .blk_in_valid_i(blk_in_valid_i), .blk_in_ready_o(blk_in_ready_o)
  );

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  // behavioural reference
  logic [31:0] in_q[$], out_q[$];
  logic        m_ierr = 0, m_oerr = 0;
  logic [31:0] m_rd = '0;

  function automatic logic [31:0] brev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      in_q.delete(); out_q.delete(); m_ierr = 0; m_oerr = 0; m_rd = '0;
    end else if (start_i) begin
      in_q.delete(); out_q.delete(); m_ierr = 0; m_oerr = 0;
    end else begin
      automatic bit take = (in_q.size() == 4) && blk_out_ready_i;
      automatic bit load = (out_q.size() == 0) && blk_in_valid_i;
      if (wr_en_i) begin
        if (in_q.size() == 4) m_ierr = 1;
        else in_q.push_back(in_swap_i ? brev(wr_data_i) : wr_data_i);
      end
      if (take) in_q.delete();
      if (rd_en_i) begin
        if (out_q.size() == 0) begin m_rd = '0; m_oerr = 1; end
        else begin
          m_rd = out_swap_i ? brev(out_q[0]) : out_q[0];
          void'(out_q.pop_front());
        end
      end
      if (load) for (int k = 0; k < 4; k++) out_q.push_back(blk_in_data_i[32*k +: 32]);
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    logic [31:0] est;
    logic [127:0] eblk;
    est = '0;
    est[8]  = (in_q.size() == 0);  est[9]  = (in_q.size() == 4);  est[10] = m_ierr;
    est[16] = (out_q.size() == 0); est[17] = (out_q.size() == 4); est[18] = m_oerr;
    chk("R2/R5 status flags", status_o[17:8] & 10'h307 | {9'b0, 1'b0}, est[17:8] & 10'h307);
    chk("R4 input error", status_o[10], est[10]);
    chk("R7/R8 output error", status_o[18], est[18]);
    chk("R1 status reserved bits", status_o & ~32'h0007_0700, '0);
    chk("R3 offer valid", blk_out_valid_o, (in_q.size() == 4) && !start_i);
    chk("R5 core ready", blk_in_ready_o, (out_q.size() == 0) && !start_i);
    chk("R6/R10 read data", rd_data_o, m_rd);
    if (in_q.size() == 4) begin
      eblk = {in_q[3], in_q[2], in_q[1], in_q[0]};
      chk("R3/R9 offered block", blk_out_data_o, eblk);
    end
  endtask

  task automatic step(input bit w, input logic [31:0] wd, input bit r,
                      input bit rdy, input bit bv, input logic [127:0] bd, input bit st);
    wr_en_i = w; wr_data_i = wd; rd_en_i = r; blk_out_ready_i = rdy;
    blk_in_valid_i = bv; blk_in_data_i = bd; start_i = st;
    @(negedge clk);
    cycles++;
    compare_all();
  endtask

  task automatic idle(); step(0, '0, 0, 0, 0, '0, 0); endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0;
    idle();
    // R1: reset state
    chk("R1 reset status", status_o, 32'h0001_0100);
    // R2/R3: fill input with four words, core not ready
    step(1, 32'h0302_0100, 0, 0, 0, '0, 0);
    chk("R2 not empty after one word", status_o[8], 1'b0);
    step(1, 32'h1312_1110, 0, 0, 0, '0, 0);
    step(1, 32'h2322_2120, 0, 0, 0, '0, 0);
    step(1, 32'h3332_3130, 0, 0, 0, '0, 0);
    chk("R3 block ordering", blk_out_data_o, 128'h3332_3130_2322_2120_1312_1110_0302_0100);
    // R4: overrun write dropped
    step(1, 32'hDEAD_BEEF, 0, 0, 0, '0, 0);
    chk("R4 overrun flag", status_o[10], 1'b1);
    chk("R4 block unchanged", blk_out_data_o, 128'h3332_3130_2322_2120_1312_1110_0302_0100);
    step(0, '0, 0, 1, 0, '0, 0);
    chk("R3 take empties input", status_o[8], 1'b1);
    chk("R8 input error sticky", status_o[10], 1'b1);
    // R5/R6: load a result block and drain
    step(0, '0, 0, 0, 1, 128'hA3A2A1A0_B3B2B1B0_C3C2C1C0_D3D2D1D0, 0);
    chk("R5 output full", status_o[17], 1'b1);
    step(0, '0, 1, 0, 1, 128'h1, 0);
    chk("R6 first word", rd_data_o, 32'hD3D2D1D0);
    out_swap_i = 1;
    step(0, '0, 1, 0, 0, '0, 0);
    chk("R10 swapped read", rd_data_o, 32'hC0C1C2C3);
    out_swap_i = 0;
    step(0, '0, 1, 0, 0, '0, 0);
    step(0, '0, 1, 0, 0, '0, 0);
    chk("R6 last word", rd_data_o, 32'hA3A2A1A0);
    // R7: underrun
    step(0, '0, 1, 0, 0, '0, 0);
    chk("R7 underrun zero", rd_data_o, 32'h0);
    chk("R7 underrun flag", status_o[18], 1'b1);
    // R9: input swap
    in_swap_i = 1;
    step(1, 32'h4433_2211, 0, 0, 0, '0, 0);
    in_swap_i = 0;
    // R11/R8: start with simultaneous write/read/handshakes ignored
    step(1, 32'h5555_5555, 1, 1, 1, 128'hF, 1);
    chk("R8 start clears", status_o, 32'h0001_0100);
    chk("R11 read ignored on start", rd_data_o, 32'h0);
    // R9: fresh block with swap on
    in_swap_i = 1;
    for (int k = 0; k < 4; k++) step(1, 32'h0A0B_0C00 + k, 0, 0, 0, '0, 0);
    in_swap_i = 0;
    chk("R9 swapped word0", blk_out_data_o[31:0], 32'h000C_0B0A);
    step(0, '0, 0, 1, 0, '0, 0);
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      in_swap_i  = $urandom_range(0, 1);
      out_swap_i = $urandom_range(0, 1);
      step($urandom_range(0, 2) != 0, $urandom, $urandom_range(0, 2) != 0,
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
           {$urandom, $urandom, $urandom, $urandom}, $urandom_range(0, 63) == 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule